// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state of a peripheral that has several internal event sources, such as timers and a serial shifter. Each source reports an event through a one-cycle set strobe on its own flag bit. Other logic that consumes an event returns a one-cycle clear strobe. Software reaches the block through an 8-bit register port at two register indices. At one index it reads the flags or acknowledges them. At the other it reads or changes the per-source enables.

Bit 7 of each register carries control or summary meaning instead of a flag. When the enable register is written, data bit 7 decides whether the ones in bits 6:0 set enables or clear them. When the flag register is read, bit 7 shows whether any pending flag is also enabled. When the enable register is read, bit 7 always returns 1.

A single level-sensitive interrupt line is raised only for the sources chosen by a fixed mask. With the default mask these are the shifter at bit 2 and the first timer at bit 6. The second timer at bit 5 can be flagged and enabled, and it shows in the bit-7 summary, but it never drives the line.

Top module: `irq_flag_enable`

## Requirements
- R1: After reset, all flags and all enables are 0, `irq_o` is low, a flag read returns 0x00 and an enable read returns 0x80.
- R2: A 1 on `src_set[i]` makes flag i read as 1 from the next clock edge on. The flag stays set until a clear removes it. A flag bit never becomes 1 without a set strobe.
- R3: A write at the flag index (index 13) clears every flag whose data bit 6:0 is 1. Data bit 7 and the zero bits leave the flags unchanged.
- R4: A 1 on `src_clr[i]` clears flag i at the next clock edge.
- R5: If a set strobe meets a clear on the same bit in the same cycle, the set wins and the flag ends at 1. This holds whether the clear comes from a strobe or from a flag write.
- R6: A write at the enable index (index 14) with data bit 7 = 1 ORs data bits 6:0 into the enables.
- R7: A write at the enable index with data bit 7 = 0 clears every enable whose data bit 6:0 is 1. All other enables keep their value.
- R8: A flag read returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag and the enable at the same position are both 1, at any of the seven positions.
- R9: An enable read returns the enables in bits 6:0, with bit 7 always 1.
- R10: `irq_o` is high exactly when some bit in mask 0x44 (shifter bit 2, first timer bit 6) has both its flag and its enable set. A pending, enabled bit 5 alone leaves `irq_o` low.
- R11: The register index is `bus_addr[12:9]` and address bits 8:0 are ignored. Writes at any index other than 13 or 14 change no flag and no enable. Reads at any other index return 0x00.
- R12: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 13 | Byte address; bits 12:9 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read enable; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| src_set | input | 7 | Per-source set strobes |
| src_clr | input | 7 | Per-source clear strobes from read side effects elsewhere |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at the same-cycle collisions between set strobes and both kinds of clear. A design that gave the clear priority would lose an event arriving in the acknowledge cycle, and the flag would read back as 0. It also separates the bit-7 summary from the interrupt line with a pending, enabled second-timer bit. A design that used one mask for both would either raise `irq_o` or drop the summary bit. Enable writes in both polarities check that a clear-mode write touches only the selected bits. Accesses at unused indices, with non-zero low address bits and with bit 7 set in flag-clear data, check that the decode and data masking never disturb the stored state.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int DATA_W = 8;
  localparam int SRC_W  = DATA_W - 1;
  localparam int CTL_BIT = DATA_W - 1;

  typedef logic [SRC_W-1:0]  src_vec_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic flag_wr;
    logic flag_rd;
    logic en_wr;
    logic en_rd;
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regs_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int FLAG_IDX = 13,
  parameter int EN_IDX   = 14
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wr,
  input  logic             rd,
  output reg_sel_t         sel
);
  localparam logic [IDX_W-1:0] FLAG_CODE = IDX_W'(FLAG_IDX);
  localparam logic [IDX_W-1:0] EN_CODE   = IDX_W'(EN_IDX);

  logic hit_flag;
  logic hit_en;

  always_comb begin
    hit_flag    = (idx == FLAG_CODE);
    hit_en      = (idx == EN_CODE);
    sel.flag_wr = wr & hit_flag;
    sel.flag_rd = rd & hit_flag;
    sel.en_wr   = wr & hit_en;
    sel.en_rd   = rd & hit_en;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_regs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  input  logic     wr_clr_i,
  input  src_vec_t wr_data_i,
  output src_vec_t flag_q
);
  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    logic hit_clr;
    logic upd;
    logic bit_d;
    logic bit_q;

    // Set dominates: on any update the new value equals the set strobe.
    always_comb begin
      hit_clr = clr_i[b] | (wr_clr_i & wr_data_i[b]);
      upd     = set_i[b] | hit_clr;
      bit_d   = set_i[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (upd) begin
        bit_q <= bit_d;
      end
    end

    assign flag_q[b] = bit_q;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_regs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  data_t    wdata_i,
  output src_vec_t en_q
);
  src_vec_t en_d;

  always_comb begin
    en_d = en_q;
    if (wdata_i[CTL_BIT]) begin
      en_d = en_q | wdata_i[SRC_W-1:0];
    end else begin
      en_d = en_q & ~wdata_i[SRC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irq_readout.sv
module irq_readout
  import irq_regs_pkg::*;
#(
  parameter logic [irq_regs_pkg::SRC_W-1:0] LINE_MASK = 7'h44
) (
  input  src_vec_t flag_i,
  input  src_vec_t en_i,
  input  logic     flag_rd_i,
  input  logic     en_rd_i,
  output data_t    rdata_o,
  output logic     irq_o
);
  src_vec_t pend;

  always_comb begin
    pend  = flag_i & en_i;
    irq_o = |(pend & LINE_MASK);
    unique case (1'b1)
      flag_rd_i: rdata_o = {|pend, flag_i};
      en_rd_i:   rdata_o = {1'b1, en_i};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int IDX_LSB  = 9,
  parameter int IDX_W    = 4,
  parameter int FLAG_IDX = 13,
  parameter int EN_IDX   = 14,
  parameter logic [irq_regs_pkg::SRC_W-1:0] LINE_MASK = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [6:0]        src_set,
  input  logic [6:0]        src_clr,
  output logic              irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             unused_addr;
  reg_sel_t         sel;
  src_vec_t         flag_q;
  src_vec_t         en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign idx         = bus_addr[IDX_LSB +: IDX_W];
  assign unused_addr = ^bus_addr;

  irq_reg_decode #(
    .IDX_W    (IDX_W),
    .FLAG_IDX (FLAG_IDX),
    .EN_IDX   (EN_IDX)
  ) u_decode (
    .idx (idx),
    .wr  (bus_wr),
    .rd  (bus_rd),
    .sel (sel)
  );

  irq_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (src_set),
    .clr_i     (src_clr),
    .wr_clr_i  (sel.flag_wr),
    .wr_data_i (bus_wdata[SRC_W-1:0]),
    .flag_q    (flag_q)
  );

  irq_enable_reg u_enables (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (sel.en_wr),
    .wdata_i (bus_wdata),
    .en_q    (en_q)
  );

  irq_readout #(
    .LINE_MASK (LINE_MASK)
  ) u_readout (
    .flag_i    (flag_q),
    .en_i      (en_q),
    .flag_rd_i (sel.flag_rd),
    .en_rd_i   (sel.en_rd),
    .rdata_o   (bus_rdata),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/irq_flag_enable_chk.sv
module irq_flag_enable_chk #(
  parameter int ADDR_W   = 13,
  parameter int IDX_LSB  = 9,
  parameter int IDX_W    = 4,
  parameter int FLAG_IDX = 13,
  parameter int EN_IDX   = 14,
  parameter logic [6:0] LINE_MASK = 7'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [6:0]        src_set,
  input logic [6:0]        src_clr,
  input logic              irq_o,
  input logic [6:0]        flag_q,
  input logic [6:0]        en_q
);
  logic [IDX_W-1:0] c_idx;
  logic             c_flag_wr;
  logic             c_en_wr;
  assign c_idx     = bus_addr[IDX_LSB +: IDX_W];
  assign c_flag_wr = bus_wr && (c_idx == IDX_W'(FLAG_IDX));
  assign c_en_wr   = bus_wr && (c_idx == IDX_W'(EN_IDX));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == 7'h0) |=> ((flag_q & ~$past(flag_q)) == 7'h0));

  p_write_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_flag_wr |=> ((flag_q & $past(bus_wdata[6:0] & ~src_set)) == 7'h0));

  p_strobe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |=> ((flag_q & $past(src_clr & ~src_set)) == 7'h0));

  p_en_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en_wr && bus_wdata[7]) |=> (en_q == ($past(en_q) | $past(bus_wdata[6:0]))));

  p_en_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en_wr && !bus_wdata[7]) |=> (en_q == ($past(en_q) & ~$past(bus_wdata[6:0]))));

  p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en_wr |=> $stable(en_q));

  p_en_read_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && c_idx == IDX_W'(EN_IDX)) |-> bus_rdata[7]);

  p_line_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q & LINE_MASK) == 7'h0) |-> !irq_o);

  p_idle_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind irq_flag_enable irq_flag_enable_chk #(
  .ADDR_W    (ADDR_W),
  .IDX_LSB   (IDX_LSB),
  .IDX_W     (IDX_W),
  .FLAG_IDX  (FLAG_IDX),
  .EN_IDX    (EN_IDX),
  .LINE_MASK (LINE_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .src_set   (src_set),
  .src_clr   (src_clr),
  .irq_o     (irq_o),
  .flag_q    (flag_q),
  .en_q      (en_q)
);

// File: tb/irq_flag_enable_bench.sv
module irq_flag_enable_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [6:0]  src_set = '0;
  logic [6:0]  src_clr = '0;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int m_flag   = 0;
  int m_en     = 0;

  always #10 clk = ~clk;

  irq_flag_enable u_irq_flag_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .irq_o     (irq_o)
  );

  function automatic logic [12:0] at(input int idx, input int low);
    return 13'((idx << 9) | (low & 'h1ff));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after a falling edge, check read data, let the
  // rising edge act, update the model, then check the interrupt line.
  task automatic cyc(input string req, input logic [12:0] a, input logic wr,
                     input logic rd, input int wd, input int st, input int cl);
    int idx;
    int exp_rd;
    int wclr;
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = 8'(wd);
    src_set = 7'(st); src_clr = 7'(cl);
    idx = (int'(a) >> 9) & 'hf;
    #5;
    exp_rd = 0;
    if (rd && idx == 13) exp_rd = (((m_flag & m_en) != 0) ? 'h80 : 0) | m_flag;
    else if (rd && idx == 14) exp_rd = 'h80 | m_en;
    check(req, int'(bus_rdata), exp_rd);
    @(posedge clk);
    wclr = (wr && idx == 13) ? (wd & 'h7f) : 0;
    m_flag = ((m_flag & ~wclr & ~cl) | st) & 'h7f;
    if (wr && idx == 14) begin
      if ((wd & 'h80) != 0) m_en = (m_en | wd) & 'h7f;
      else m_en = m_en & ~wd & 'h7f;
    end
    @(negedge clk);
    check(req, int'(irq_o), ((m_flag & m_en & 'h44) != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    cyc("R1 flag read", at(13, 0), 0, 1, 0, 0, 0);
    cyc("R1 enable read", at(14, 0), 0, 1, 0, 0, 0);
    // R2: set without enable
    cyc("R2 set shifter", at(0, 0), 0, 0, 0, 'h04, 0);
    cyc("R2 idle hold", at(0, 0), 0, 0, 0, 0, 0);
    cyc("R2 flag read", at(13, 0), 0, 1, 0, 0, 0);
    // R6 / R10: enable shifter raises line
    cyc("R6 enable or", at(14, 0), 1, 0, 'h84, 0, 0);
    cyc("R8 summary read", at(13, 0), 0, 1, 0, 0, 0);
    cyc("R9 enable read", at(14, 0), 0, 1, 0, 0, 0);
    // R3: flag write clears, bit 7 and zeros ignored
    cyc("R3 clear none", at(13, 0), 1, 0, 'h80, 0, 0);
    cyc("R3 clear none read", at(13, 0), 0, 1, 0, 0, 0);
    cyc("R3 clear shifter", at(13, 0), 1, 0, 'h04, 0, 0);
    cyc("R3 read after", at(13, 0), 0, 1, 0, 0, 0);
    // R8 / R10: second timer pending and enabled, line stays low
    cyc("R10 set t2", at(0, 0), 0, 0, 0, 'h20, 0);
    cyc("R10 enable t2", at(14, 0), 1, 0, 'hA0, 0, 0);
    cyc("R8 t2 summary", at(13, 0), 0, 1, 0, 0, 0);
    // R10: first timer raises line
    cyc("R10 set t1", at(0, 0), 0, 0, 0, 'h40, 0);
    cyc("R10 enable t1", at(14, 0), 1, 0, 'hC0, 0, 0);
    // R4: strobe clear
    cyc("R4 strobe clear t1", at(0, 0), 0, 0, 0, 0, 'h40);
    cyc("R4 read", at(13, 0), 0, 1, 0, 0, 0);
    // R5: set beats clear
    cyc("R5 set vs strobe", at(0, 0), 0, 0, 0, 'h40, 'h40);
    cyc("R5 read", at(13, 0), 0, 1, 0, 0, 0);
    cyc("R5 set vs write", at(13, 0), 1, 0, 'h04, 'h04, 0);
    cyc("R5 read 2", at(13, 0), 0, 1, 0, 0, 0);
    // R7: clear-mode enable write touches only selected bits
    cyc("R7 clear en t1", at(14, 0), 1, 0, 'h40, 0, 0);
    cyc("R7 enable read", at(14, 0), 0, 1, 0, 0, 0);
    cyc("R7 clear en shifter", at(14, 0), 1, 0, 'h04, 0, 0);
    cyc("R7 enable read 2", at(14, 0), 0, 1, 0, 0, 0);
    // R11: other indices and low address bits
    cyc("R11 write idx12", at(12, 0), 1, 0, 'hFF, 0, 0);
    cyc("R11 write idx15", at(15, 0), 1, 0, 'h7F, 0, 0);
    cyc("R11 write idx5", at(5, 3), 1, 0, 'h00, 0, 0);
    cyc("R11 read idx12", at(12, 0), 0, 1, 0, 0, 0);
    cyc("R11 flag low bits", at(13, 'h1ff), 0, 1, 0, 0, 0);
    cyc("R11 en low bits", at(14, 'h0a5), 0, 1, 0, 0, 0);
    cyc("R11 en or low bits", at(14, 'h101), 1, 0, 'hC4, 0, 0);
    // R12: no read, no data
    cyc("R12 idle flag", at(13, 0), 0, 0, 0, 0, 0);
    cyc("R12 idle en", at(14, 0), 0, 0, 0, 0, 0);
    // mixed: multiple bits at once
    cyc("R2 multi set", at(0, 0), 0, 0, 0, 'h7f, 'h10);
    cyc("R3 multi clear", at(13, 0), 1, 0, 'h3b, 0, 0);
    cyc("R8 final read", at(13, 0), 0, 1, 0, 0, 0);
    cyc("R4 clear all", at(0, 0), 0, 0, 0, 0, 'h7f);
    cyc("R8 empty read", at(13, 0), 0, 1, 0, 0, 0);
    // R1: reset again mid-run
    rst_n = 1'b0;
    m_flag = 0; m_en = 0;
    @(negedge clk);
    check("R1 irq after reset", int'(irq_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc("R1 en after reset", at(14, 0), 0, 1, 0, 0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule